// File: doc/BRIEF.md
# USB Host Controller State and Interrupt Core

This block is the control and status heart of a full/low-speed USB host controller. It owns the functional-state machine (Reset, Resume, Operational, Suspend), the command/status word, the interrupt status and interrupt enable words, the periodic-start and low-speed-threshold values, and the 16-bit frame number. A frame timer runs only while the controller is Operational. Each time the timer wraps it produces a start-of-frame event that advances the frame number and flags an interrupt.

Software reaches the block over a simple 32-bit register bus. Addresses are byte addresses, and every register sits on a 32-bit word. A single level interrupt output summarises the enabled status bits. The surrounding controller (list processing, DMA, port logic) reports its own interrupt causes on an event input and a remote-wakeup strobe. It receives a root-hub reset pulse from this block.

Two reset depths exist. The module reset input is a hard reset that clears everything. Software can also request a lighter soft reset, which keeps the interrupt-routing bit and the interrupt enables.

Top module: `hc_state_irq`

## Requirements
- R1: After hard reset (`rst_n` low), control reads 0 (state Reset), interrupt enable reads 0, interrupt status reads 0, frame number reads 0, low-speed threshold reads 0x628, and `hub_rst_o` stays high for exactly one cycle after `rst_n` is released.
- R2: Writing 1 to bit 0 of the command/status word (offset 0x04) performs a soft reset. The control word keeps only bit 8 (interrupt routing) and its state field becomes Suspend. Command/status, interrupt status, frame number and periodic start are cleared. Low-speed threshold returns to 0x628. Interrupt enables are kept.
- R3: Writing the control word (offset 0x00) with state field bits [7:6] = 00 (Reset) while the state is not already Reset pulses `hub_rst_o` for one cycle. It leaves the periodic start and low-speed threshold unchanged.
- R4: In state Operational (bits [7:6] = 10), the first start-of-frame occurs FRAME_CYC cycles after the control write. Later ones follow every FRAME_CYC cycles. Each one increments the frame number (offset 0x14) and sets status bit 2.
- R5: The frame timer runs only in Operational. Entering Suspend (bits [7:6] = 11) clears status bit 2, and the frame number then stays constant.
- R6: Status bit 5 is set when a start-of-frame changes bit 15 of the frame number.
- R7: A `wake_i` pulse while in Suspend moves the state to Resume (01) and sets status bit 3. In any other state it has no effect.
- R8: Interrupt status (offset 0x08) holds only bits 0 to 6 and 30. `evt_i` sets bits 0, 1, 3, 4, 6 and 30. Writing 1 to a status bit clears it, and a set in the same cycle wins. Other bits read 0.
- R9: Writing 1s to offset 0x0C sets enable bits, and writing 1s to offset 0x10 clears them. Both offsets read the enable word. Bit 31 is the master enable.
- R10: `irq_o` is high exactly when master enable is set and some status bit is set whose enable bit is also set.
- R11: A read at an address with bits [1:0] not 00 returns 0xFFFFFFFF, and a write there changes nothing. A read of any offset above 0x1C returns 0xFFFFFFFF.
- R12: Periodic start (offset 0x18) is 14 bits wide. Low-speed threshold (offset 0x1C) is 12 bits wide. Command/status keeps bits [3:0], and writes OR into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_i | input | 32 | Interrupt causes from the rest of the controller, one-cycle pulses |
| wake_i | input | 1 | Remote-wakeup strobe |
| irq_o | output | 1 | Level interrupt request |
| sof_o | output | 1 | High in the cycle that ends each frame |
| hub_rst_o | output | 1 | Root-hub reset request pulse |

## Verification
A wrong functional state is visible on the next read of the control word. It also shows within one frame period, because the frame number either moves when it should hold or holds when it should move. A frame counter that is off by even one cycle changes which cycle first shows frame 1. For this reason the start-of-frame checks sample the cycle before and the cycle of the expected change. Status or enable corruption reaches `irq_o` in the cycle after the offending edge. The frame-overflow flag is observed only after 32768 frames, so the bench runs the timer that far with a shortened frame.

// File: rtl/hcsi_pkg.sv
package hcsi_pkg;

  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } fstate_e;

  localparam int CTL_W  = 11;
  localparam int FS_LSB = 6;
  localparam int IR_BIT = 8;
  localparam int CMD_W  = 4;
  localparam int PS_W   = 14;
  localparam int LST_W  = 12;
  localparam int FN_W   = 16;

  localparam int B_SO   = 0;
  localparam int B_WD   = 1;
  localparam int B_SF   = 2;
  localparam int B_RD   = 3;
  localparam int B_UE   = 4;
  localparam int B_FNO  = 5;
  localparam int B_RHSC = 6;
  localparam int B_OC   = 30;
  localparam int B_MIE  = 31;

  localparam logic [31:0] STS_MASK = (32'h1 << B_SO) | (32'h1 << B_WD) | (32'h1 << B_SF) |
                                     (32'h1 << B_RD) | (32'h1 << B_UE) | (32'h1 << B_FNO) |
                                     (32'h1 << B_RHSC) | (32'h1 << B_OC);
  localparam logic [31:0] EXT_MASK = STS_MASK & ~((32'h1 << B_SF) | (32'h1 << B_FNO));
  localparam logic [31:0] EN_MASK  = STS_MASK | (32'h1 << B_MIE);

  localparam int W_CTL = 0;
  localparam int W_CMD = 1;
  localparam int W_STS = 2;
  localparam int W_ENS = 3;
  localparam int W_ENC = 4;
  localparam int W_FN  = 5;
  localparam int W_PS  = 6;
  localparam int W_LST = 7;

  function automatic logic [FN_W-1:0] frame_next(input logic [FN_W-1:0] fn);
    return fn + 1'b1;
  endfunction

  function automatic logic fno_hit(input logic [FN_W-1:0] prev, input logic [FN_W-1:0] nxt);
    return prev[FN_W-1] ^ nxt[FN_W-1];
  endfunction

  function automatic logic irq_level(input logic [31:0] sts, input logic [31:0] en);
    return en[B_MIE] && ((sts & en & STS_MASK) != 32'h0);
  endfunction

endpackage

// File: rtl/hcsi_frame_timer.sv
module hcsi_frame_timer #(
  parameter int FRAME_CYC = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sof_evt
);
  localparam int CNT_W = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // the counter sits at zero whenever the controller is not Operational,
  // so the first wrap comes one whole frame after entering that state
  assign sof_evt = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run || sof_evt)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hcsi_irq_regs.sv
module hcsi_irq_regs
  import hcsi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_clr,
  input  logic        clr_sf,
  input  logic [31:0] set_vec,
  input  logic [31:0] w1c_vec,
  input  logic [31:0] en_set,
  input  logic [31:0] en_clr,
  output logic [31:0] sts_q,
  output logic [31:0] en_q,
  output logic        irq_o
);
  logic [31:0] sts_n;
  logic [31:0] en_n;

  always_comb begin
    sts_n = ((sts_q & ~w1c_vec) | set_vec) & STS_MASK;
    if (clr_sf)   sts_n[B_SF] = 1'b0;
    if (soft_clr) sts_n = '0;
    en_n = ((en_q | en_set) & ~en_clr) & EN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_n;
      en_q  <= en_n;
    end
  end

  assign irq_o = irq_level(sts_q, en_q);
endmodule

// File: rtl/hc_state_irq.sv
module hc_state_irq
  import hcsi_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          FRAME_CYC = 12000,
  parameter logic [11:0] LST_RST   = 12'h628
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_i,
  input  logic              wake_i,
  output logic              irq_o,
  output logic              sof_o,
  output logic              hub_rst_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [CTL_W-1:0] ctl_q, ctl_n;
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic [PS_W-1:0]  ps_q, ps_n;
  logic [LST_W-1:0] lst_q, lst_n;
  logic [FN_W-1:0]  frame_q, frame_n;
  logic             hub_q;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              ctl_wr, cmd_wr, sts_wr, ens_wr, enc_wr, ps_wr, lst_wr;
  logic              soft_rst, wake_ok, clr_sf, sof_evt, fno_evt, hub_req;
  logic [1:0]        fs_q, fs_n;
  logic [31:0]       set_vec, sts_w, en_w;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign ctl_wr  = bus_wr && aligned && (word == WORD_W'(W_CTL));
  assign cmd_wr  = bus_wr && aligned && (word == WORD_W'(W_CMD));
  assign sts_wr  = bus_wr && aligned && (word == WORD_W'(W_STS));
  assign ens_wr  = bus_wr && aligned && (word == WORD_W'(W_ENS));
  assign enc_wr  = bus_wr && aligned && (word == WORD_W'(W_ENC));
  assign ps_wr   = bus_wr && aligned && (word == WORD_W'(W_PS));
  assign lst_wr  = bus_wr && aligned && (word == WORD_W'(W_LST));

  assign fs_q     = ctl_q[FS_LSB +: 2];
  assign soft_rst = cmd_wr && bus_wdata[0];
  assign wake_ok  = wake_i && (fs_q == FS_SUSPEND) && !ctl_wr && !soft_rst;
  assign hub_req  = ctl_wr && (bus_wdata[FS_LSB +: 2] == FS_RESET) && (fs_q != FS_RESET);

  hcsi_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (fs_q == FS_OPER),
    .sof_evt (sof_evt)
  );

  always_comb begin
    ctl_n = ctl_q;
    if (soft_rst) begin
      ctl_n = '0;
      ctl_n[IR_BIT] = ctl_q[IR_BIT];
      ctl_n[FS_LSB +: 2] = FS_SUSPEND;
    end else if (ctl_wr) begin
      ctl_n = bus_wdata[CTL_W-1:0];
    end else if (wake_ok) begin
      ctl_n[FS_LSB +: 2] = FS_RESUME;
    end
    fs_n = ctl_n[FS_LSB +: 2];

    frame_n = sof_evt ? frame_next(frame_q) : frame_q;
    fno_evt = sof_evt && fno_hit(frame_q, frame_n);
    cmd_n   = cmd_wr ? (cmd_q | bus_wdata[CMD_W-1:0]) : cmd_q;
    ps_n    = ps_wr  ? bus_wdata[PS_W-1:0]  : ps_q;
    lst_n   = lst_wr ? bus_wdata[LST_W-1:0] : lst_q;
    if (soft_rst) begin
      frame_n = '0;
      cmd_n   = '0;
      ps_n    = '0;
      lst_n   = LST_RST;
    end
  end

  assign clr_sf = (fs_n == FS_SUSPEND) && (fs_q != FS_SUSPEND);

  always_comb begin
    set_vec = evt_i & EXT_MASK;
    if (sof_evt) set_vec[B_SF]  = 1'b1;
    if (fno_evt) set_vec[B_FNO] = 1'b1;
    if (wake_ok) set_vec[B_RD]  = 1'b1;
  end

  hcsi_irq_regs u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_rst),
    .clr_sf   (clr_sf),
    .set_vec  (set_vec),
    .w1c_vec  (sts_wr ? bus_wdata : 32'h0),
    .en_set   (ens_wr ? bus_wdata : 32'h0),
    .en_clr   (enc_wr ? bus_wdata : 32'h0),
    .sts_q    (sts_w),
    .en_q     (en_w),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      cmd_q   <= '0;
      ps_q    <= '0;
      lst_q   <= LST_RST;
      frame_q <= '0;
      hub_q   <= 1'b1;
    end else begin
      ctl_q   <= ctl_n;
      cmd_q   <= cmd_n;
      ps_q    <= ps_n;
      lst_q   <= lst_n;
      frame_q <= frame_n;
      hub_q   <= hub_req;
    end
  end

  assign hub_rst_o = hub_q;
  assign sof_o     = sof_evt;

  always_comb begin
    bus_rdata = 32'hFFFF_FFFF;
    if (aligned) begin
      case (word)
        WORD_W'(W_CTL): bus_rdata = 32'(ctl_q);
        WORD_W'(W_CMD): bus_rdata = 32'(cmd_q);
        WORD_W'(W_STS): bus_rdata = sts_w;
        WORD_W'(W_ENS),
        WORD_W'(W_ENC): bus_rdata = en_w;
        WORD_W'(W_FN):  bus_rdata = 32'(frame_q);
        WORD_W'(W_PS):  bus_rdata = 32'(ps_q);
        WORD_W'(W_LST): bus_rdata = 32'(lst_q);
        default:        bus_rdata = 32'hFFFF_FFFF;
      endcase
    end
  end
endmodule

// File: rtl/hcsi_chk.sv
module hcsi_chk
  import hcsi_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  fs,
  input logic        sof_evt,
  input logic        sts_sf,
  input logic        sts_fno,
  input logic        en_mie,
  input logic        irq_o,
  input logic        wake_i,
  input logic        ctl_wr,
  input logic        soft_rst,
  input logic        hub_rst_o,
  input logic [14:0] frame_lo
);
  // R4 / R5: frame events only while Operational
  a_r4_sof_only_oper: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |-> (fs == FS_OPER));

  // R5: arriving in Suspend leaves no start-of-frame flag pending
  a_r5_suspend_drops_sf: assert property (@(posedge clk) disable iff (!rst_n)
    ((fs == FS_SUSPEND) && ($past(fs) != FS_SUSPEND)) |-> !sts_sf);

  // R6: crossing into the upper half of the frame range raises overflow
  a_r6_fno_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_evt && (frame_lo == 15'h7FFF) && !soft_rst) |=> sts_fno);

  // R7: wakeup from Suspend lands in Resume
  a_r7_wake_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i && (fs == FS_SUSPEND) && !ctl_wr && !soft_rst) |=> (fs == FS_RESUME));

  // R10: no request without the master enable
  a_r10_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_mie);

  // R3: the hub reset pulse only accompanies the Reset state
  a_r3_hub_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hub_rst_o |-> (fs == FS_RESET));
endmodule

bind hc_state_irq hcsi_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fs        (fs_q),
  .sof_evt   (sof_evt),
  .sts_sf    (sts_w[2]),
  .sts_fno   (sts_w[5]),
  .en_mie    (en_w[31]),
  .irq_o     (irq_o),
  .wake_i    (wake_i),
  .ctl_wr    (ctl_wr),
  .soft_rst  (soft_rst),
  .hub_rst_o (hub_rst_o),
  .frame_lo  (frame_q[14:0])
);

// File: tb/sim_hc_state_irq.sv
module sim_hc_state_irq;
  localparam int F = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_i = 32'h0;
  logic        wake_i = 1'b0;
  logic        irq_o, sof_o, hub_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hc_state_irq #(.ADDR_W(8), .FRAME_CYC(F)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .wake_i(wake_i), .irq_o(irq_o), .sof_o(sof_o), .hub_rst_o(hub_rst_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0,          32'h0},           // R1 control after reset
    '{1'b0, 8'h1C, 32'h0,          32'h628},         // R1 threshold after reset
    '{1'b0, 8'h14, 32'h0,          32'h0},           // R1 frame after reset
    '{1'b1, 8'h18, 32'hFFFF_FFFF,  32'h0},
    '{1'b0, 8'h18, 32'h0,          32'h3FFF},        // R12 periodic start width
    '{1'b1, 8'h1C, 32'h0000_0123,  32'h0},
    '{1'b0, 8'h1C, 32'h0,          32'h123},         // R12 threshold
    '{1'b1, 8'h0C, 32'h8000_0044,  32'h0},
    '{1'b0, 8'h0C, 32'h0,          32'h8000_0044},   // R9 set
    '{1'b1, 8'h10, 32'h0000_0004,  32'h0},
    '{1'b0, 8'h10, 32'h0,          32'h8000_0040},   // R9 clear
    '{1'b0, 8'h22, 32'h0,          32'hFFFF_FFFF},   // R11 unaligned read
    '{1'b1, 8'h19, 32'h0,          32'h0},
    '{1'b0, 8'h18, 32'h0,          32'h3FFF},        // R11 unaligned write ignored
    '{1'b0, 8'h20, 32'h0,          32'hFFFF_FFFF},   // R11 unknown offset
    '{1'b1, 8'h04, 32'h0000_0006,  32'h0},
    '{1'b0, 8'h04, 32'h0,          32'h6},           // R12 command bits
    '{1'b0, 8'h08, 32'h0,          32'h0}            // R8 status empty
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [31:0] v);
    @(negedge clk);
    evt_i = v;
    @(negedge clk);
    evt_i = 32'h0;
  endtask

  task automatic pulse_wake();
    @(negedge clk);
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 hub reset after release", 32'(hub_rst_o), 32'h1);
    @(negedge clk);
    #1 check("R1 hub reset one cycle", 32'(hub_rst_o), 32'h0);
    rd_reg(8'h0C, v); check("R1 enable zero", v, 32'h0);
    check("R10 irq idle", 32'(irq_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr_reg(VEC[i].addr, VEC[i].data);
      else begin
        rd_reg(VEC[i].addr, v);
        checks++;
        if (v !== VEC[i].exp) begin
          fails++;
          $display("FAIL vector %0d addr=%h actual=%h expected=%h", i, VEC[i].addr, v, VEC[i].exp);
        end
      end
    end

    // R2 soft reset
    wr_reg(8'h00, 32'h140);
    rd_reg(8'h00, v); check("R12 control readback", v, 32'h140);
    pulse_evt(32'h1);
    wr_reg(8'h04, 32'h1);
    rd_reg(8'h00, v); check("R2 control after soft reset", v, 32'h1C0);
    rd_reg(8'h04, v); check("R2 command cleared", v, 32'h0);
    rd_reg(8'h08, v); check("R2 status cleared", v, 32'h0);
    rd_reg(8'h18, v); check("R2 periodic start cleared", v, 32'h0);
    rd_reg(8'h1C, v); check("R2 threshold reloaded", v, 32'h628);
    rd_reg(8'h0C, v); check("R2 enables kept", v, 32'h8000_0040);
    rd_reg(8'h14, v); check("R2 frame cleared", v, 32'h0);

    // R8 / R10 interrupt path
    pulse_evt(32'h1);
    #1 check("R10 unenabled source", 32'(irq_o), 32'h0);
    pulse_evt(32'h40);
    #1 check("R10 enabled source", 32'(irq_o), 32'h1);
    pulse_evt(32'h0000_0084);
    rd_reg(8'h08, v); check("R8 only defined bits", v, 32'h41);
    wr_reg(8'h08, 32'h40);
    rd_reg(8'h08, v); check("R8 write one clears", v, 32'h1);
    check("R10 irq drops", 32'(irq_o), 32'h0);
    wr_reg(8'h08, 32'h1);
    wr_reg(8'h10, 32'h8000_0000);
    pulse_evt(32'h40);
    #1 check("R9 master disabled", 32'(irq_o), 32'h0);
    wr_reg(8'h0C, 32'h8000_0000);
    #1 check("R9 master enabled", 32'(irq_o), 32'h1);
    wr_reg(8'h08, 32'h40);

    // R7 remote wakeup
    pulse_wake();
    rd_reg(8'h00, v); check("R7 suspend to resume", v, 32'h140);
    rd_reg(8'h08, v); check("R7 resume detect", v, 32'h8);
    wr_reg(8'h08, 32'h8);
    pulse_wake();
    rd_reg(8'h00, v); check("R7 ignored outside suspend", v, 32'h140);
    rd_reg(8'h08, v); check("R7 no flag outside suspend", v, 32'h0);

    // R3 root-hub reset via state field
    wr_reg(8'h18, 32'h5);
    wr_reg(8'h00, 32'h000);
    #1 check("R3 hub pulse", 32'(hub_rst_o), 32'h1);
    @(negedge clk);
    #1 check("R3 hub pulse ends", 32'(hub_rst_o), 32'h0);
    rd_reg(8'h18, v); check("R3 periodic start kept", v, 32'h5);
    rd_reg(8'h1C, v); check("R3 threshold kept", v, 32'h628);

    // R4 first frame delayed by a full period
    wr_reg(8'h00, 32'h080);
    repeat (F - 1) @(negedge clk);
    rd_reg(8'h14, v); check("R4 no early frame", v, 32'h0);
    rd_reg(8'h08, v); check("R4 no early SF", v, 32'h0);
    @(negedge clk);
    rd_reg(8'h14, v); check("R4 first frame", v, 32'h1);
    rd_reg(8'h08, v); check("R4 SF set", v, 32'h4);
    repeat (F) @(negedge clk);
    rd_reg(8'h14, v); check("R4 frame period", v, 32'h2);

    // R5 suspend stops timer and drops SF
    wr_reg(8'h00, 32'h0C0);
    rd_reg(8'h08, v); check("R5 SF cleared on suspend", v & 32'h4, 32'h0);
    rd_reg(8'h14, f0);
    repeat (10) @(negedge clk);
    rd_reg(8'h14, v); check("R5 frame frozen", v, f0);

    // R6 overflow flag on bit 15 change
    wr_reg(8'h08, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'h080);
    bus_addr = 8'h14;
    for (int k = 0; k < 120000; k++) begin
      #1;
      if (bus_rdata == 32'h7FFF) break;
      @(negedge clk);
    end
    rd_reg(8'h14, v); check("R6 reached 0x7FFF", v, 32'h7FFF);
    rd_reg(8'h08, v); check("R6 no flag before", v & 32'h20, 32'h0);
    repeat (F) @(negedge clk);
    rd_reg(8'h14, v); check("R6 reached 0x8000", v, 32'h8000);
    rd_reg(8'h08, v); check("R6 overflow flag", v & 32'h20, 32'h20);

    // R1 hard reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 hub after hard reset", 32'(hub_rst_o), 32'h1);
    rd_reg(8'h00, v); check("R1 control cleared", v, 32'h0);
    rd_reg(8'h0C, v); check("R1 enables cleared", v, 32'h0);
    rd_reg(8'h08, v); check("R1 status cleared", v, 32'h0);
    rd_reg(8'h14, v); check("R1 frame cleared", v, 32'h0);
    @(negedge clk);
    #1 check("R1 hub pulse single", 32'(hub_rst_o), 32'h0);

    summary();
  end
endmodule